// File: doc/BRIEF.md
# Iterative signed multiplier with overflow flags

This execution unit multiplies two signed integers at 8, 16, 32 or 64 bits. The caller presents a size code, a form code, two 64-bit source buses, an immediate and an immediate width bit, and raises `start_i` for one cycle. The unit samples all of these, runs an iterative Booth recoding over the selected width, and raises `done_o` for one cycle. The result words and flags appear in that same cycle and hold until the next completion.

Three forms are offered. The accumulator form returns the full double-width product. At 8 bits this is a single 16-bit value; at the larger sizes it is split into a low half and a high half. The two-operand and immediate forms return only the low operand-size bits. Overflow is reported on the carry and overflow flags. Both flags are set when the full product cannot be rebuilt by sign-extending its truncated low part. The sign flag copies the top bit of that truncated part. The zero, adjust and parity flag outputs are not defined by this operation and are tied to 0.

Top module: `smul_unit`

## Requirements
- R1: While the unit is idle, a high `start_i` at a clock edge samples every operand input. `done_o` is then high for exactly one cycle. The result and flag outputs change only in the cycle in which `done_o` rises, and hold their values until the next such cycle.
- R2: A `start_i` pulse that arrives while an operation is running is dropped. It neither changes that operation's result or timing nor produces an extra `done_o`.
- R3: The size code selects the width w: 00=8, 01=16, 10=32, 11=64. Each factor is the low w bits of its source, read as two's complement, and the product is exact signed multiplication.
- R4: For form code 00 (accumulator) at size 00, `res_lo_o[15:0]` holds the 16-bit product and `res_hi_o` is 0. At other sizes, `res_lo_o` holds product bits [w-1:0] and `res_hi_o` holds product bits [2w-1:w].
- R5: For form 01 (two-operand), form 10 (immediate) and the spare code 11, which behaves like 01, `res_lo_o` holds product bits [w-1:0] and `res_hi_o` is 0.
- R6: In form 10 the second factor comes from the immediate and `src_b_i` has no effect. With `imm_wide_i`=0 the immediate is `imm_i[7:0]`. With `imm_wide_i`=1 it is `imm_i[15:0]` at size 01, `imm_i[31:0]` at sizes 10 and 11, and `imm_i[7:0]` at size 00. The selected immediate is sign-extended to w bits.
- R7: Result bits above the delivered width are 0. For the 8-bit accumulator case that width is 16 bits; otherwise it is w bits.
- R8: `cf_o` and `of_o` are both 1 when sign-extending product bits [w-1:0] does not give the full product, and both are 0 otherwise.
- R9: `sf_o` equals product bit w-1.
- R10: While `rst_ni` is low, `done_o` and every result and flag output are 0. A reset during an operation abandons it, and no `done_o` follows.
- R11: `done_o` rises w/RADIX_LOG2 + 1 clock edges after the edge that accepted the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| size_i | input | 2 | Operand size code |
| form_i | input | 2 | Operand form code |
| src_a_i | input | XLEN | First factor (accumulator or destination) |
| src_b_i | input | XLEN | Second factor for forms 00, 01 and 11 |
| imm_i | input | IMM_W | Immediate for form 10 |
| imm_wide_i | input | 1 | Immediate width select |
| done_o | output | 1 | One-cycle completion pulse |
| res_lo_o | output | XLEN | Low result word |
| res_hi_o | output | XLEN | High result word (accumulator form) |
| sf_o | output | 1 | Sign flag |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| zf_o | output | 1 | Zero flag, undefined, driven 0 |
| af_o | output | 1 | Adjust flag, undefined, driven 0 |
| pf_o | output | 1 | Parity flag, undefined, driven 0 |

## Verification
The bench builds the unit with XLEN=64, IMM_W=32 and RADIX_LOG2=2. This brings all four size codes within reach, together with both immediate widths including the full 32-bit one. Latencies are 5, 9, 17 and 33 cycles, which is short enough to run every form at the most negative value of each size, with zero factors, and with a few hundred random operand sets. The two-bit recoding step also means that odd Booth digits (±1) and even digits (±2) both occur in every run.

// File: rtl/smul_pkg.sv
package smul_pkg;

   typedef enum logic [1:0] {
      SZ_B = 2'b00,
      SZ_H = 2'b01,
      SZ_W = 2'b10,
      SZ_D = 2'b11
   } opsz_e;

   typedef enum logic [1:0] {
      FM_ACC = 2'b00,
      FM_TWO = 2'b01,
      FM_IMM = 2'b10,
      FM_RSV = 2'b11
   } form_e;

   // operand width in bits for a size code
   function automatic int unsigned size_bits(input opsz_e s);
      return 32'd8 << s;
   endfunction

endpackage

// File: rtl/smul_opnd_prep.sv
module smul_opnd_prep
   import smul_pkg::*;
#(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned IMM_W = 32
) (
   input  logic [1:0]             size_i,
   input  logic [1:0]             form_i,
   input  logic [XLEN-1:0]        src_a_i,
   input  logic [XLEN-1:0]        src_b_i,
   input  logic [IMM_W-1:0]       imm_i,
   input  logic                   imm_wide_i,
   output logic signed [XLEN-1:0] mcand_o,
   output logic signed [XLEN-1:0] mplr_o
);

   // keep the low n bits of v and sign-fill the rest
   function automatic logic signed [XLEN-1:0] sext_n(input logic [XLEN-1:0] v,
                                                     input int unsigned n);
      logic [XLEN-1:0] t;
      t = v << (XLEN - n);
      return $signed(t) >>> (XLEN - n);
   endfunction

   int unsigned     w;
   int unsigned     imm_n;
   logic [XLEN-1:0] imm_x;

   always_comb begin
      w     = size_bits(opsz_e'(size_i));
      imm_x = XLEN'(imm_i);
      if (!imm_wide_i || size_i == SZ_B)
         imm_n = 8;
      else if (size_i == SZ_H)
         imm_n = 16;
      else
         imm_n = IMM_W;
      mcand_o = sext_n(src_a_i, w);
      if (form_i == FM_IMM)
         mplr_o = sext_n(sext_n(imm_x, imm_n), w);
      else
         mplr_o = sext_n(src_b_i, w);
   end

endmodule

// File: rtl/smul_booth_core.sv
module smul_booth_core #(
   parameter int unsigned XLEN       = 64,
   parameter int unsigned RADIX_LOG2 = 2,
   localparam int unsigned PW        = 2 * XLEN,
   localparam int unsigned CW        = $clog2(XLEN + 1)
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   go_i,
   input  logic [CW-1:0]          nsteps_i,
   input  logic signed [XLEN-1:0] mcand_i,
   input  logic signed [XLEN-1:0] mplr_i,
   output logic                   busy_o,
   output logic                   fin_o,
   output logic [PW-1:0]          prod_o
);

   logic signed [PW-1:0]   acc_q;
   logic signed [PW-1:0]   mc_q;
   logic signed [XLEN-1:0] mp_q;
   logic                   prev_q;
   logic [CW-1:0]          cnt_q;
   logic                   run_q;
   logic                   fin_q;
   logic signed [PW-1:0]   addend;

   generate
      if (RADIX_LOG2 == 2) begin : g_radix4
         always_comb begin
            unique case ({mp_q[1:0], prev_q})
               3'b001, 3'b010: addend = mc_q;
               3'b011:         addend = mc_q <<< 1;
               3'b100:         addend = -(mc_q <<< 1);
               3'b101, 3'b110: addend = -mc_q;
               default:        addend = '0;
            endcase
         end
      end else begin : g_radix2
         always_comb begin
            unique case ({mp_q[0], prev_q})
               2'b01:   addend = mc_q;
               2'b10:   addend = -mc_q;
               default: addend = '0;
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q  <= '0;
         mc_q   <= '0;
         mp_q   <= '0;
         prev_q <= 1'b0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         fin_q  <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (go_i && !run_q) begin
            acc_q  <= '0;
            mc_q   <= {{XLEN{mcand_i[XLEN-1]}}, mcand_i};
            mp_q   <= mplr_i;
            prev_q <= 1'b0;
            cnt_q  <= nsteps_i;
            run_q  <= 1'b1;
         end else if (run_q) begin
            acc_q  <= acc_q + addend;
            mc_q   <= mc_q <<< RADIX_LOG2;
            mp_q   <= mp_q >>> RADIX_LOG2;
            prev_q <= mp_q[RADIX_LOG2-1];
            cnt_q  <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               run_q <= 1'b0;
               fin_q <= 1'b1;
            end
         end
      end
   end

   assign busy_o = run_q;
   assign fin_o  = fin_q;
   assign prod_o = acc_q;

endmodule

// File: rtl/smul_result_fmt.sv
module smul_result_fmt
   import smul_pkg::*;
#(
   parameter int unsigned XLEN = 64,
   localparam int unsigned PW  = 2 * XLEN
) (
   input  logic [PW-1:0]   prod_i,
   input  logic [1:0]      size_i,
   input  logic [1:0]      form_i,
   output logic [XLEN-1:0] lo_o,
   output logic [XLEN-1:0] hi_o,
   output logic            sf_o,
   output logic            ovf_o
);

   int unsigned     w;
   logic [XLEN-1:0] mask;
   logic [XLEN-1:0] low;
   logic [XLEN-1:0] upper;
   logic [PW-1:0]   t;
   logic [PW-1:0]   trunc_sx;

   always_comb begin
      w        = size_bits(opsz_e'(size_i));
      mask     = ~({XLEN{1'b1}} << w);
      low      = prod_i[XLEN-1:0] & mask;
      upper    = XLEN'(prod_i >> w) & mask;
      t        = PW'(prod_i[XLEN-1:0]) << (PW - w);
      trunc_sx = $signed(t) >>> (PW - w);
      ovf_o    = (trunc_sx != prod_i);
      sf_o     = |(low & (XLEN'(1) << (w - 1)));
      if (form_i == FM_ACC) begin
         if (size_i == SZ_B) begin
            lo_o = XLEN'(prod_i[15:0]);
            hi_o = '0;
         end else begin
            lo_o = low;
            hi_o = upper;
         end
      end else begin
         lo_o = low;
         hi_o = '0;
      end
   end

endmodule

// File: rtl/smul_unit.sv
module smul_unit
   import smul_pkg::*;
#(
   parameter int unsigned XLEN       = 64,
   parameter int unsigned IMM_W      = 32,
   parameter int unsigned RADIX_LOG2 = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [1:0]        size_i,
   input  logic [1:0]        form_i,
   input  logic [XLEN-1:0]   src_a_i,
   input  logic [XLEN-1:0]   src_b_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              imm_wide_i,
   output logic              done_o,
   output logic [XLEN-1:0]   res_lo_o,
   output logic [XLEN-1:0]   res_hi_o,
   output logic              sf_o,
   output logic              cf_o,
   output logic              of_o,
   output logic              zf_o,
   output logic              af_o,
   output logic              pf_o
);

   localparam int unsigned PW = 2 * XLEN;
   localparam int unsigned CW = $clog2(XLEN + 1);

   generate
      if (XLEN != 64) begin : g_bad_xlen
         $error("smul_unit: size codes span 8..64 bits, XLEN must be 64");
      end
      if (IMM_W < 16 || IMM_W > XLEN) begin : g_bad_imm
         $error("smul_unit: IMM_W must lie between 16 and XLEN");
      end
      if (RADIX_LOG2 != 1 && RADIX_LOG2 != 2) begin : g_bad_radix
         $error("smul_unit: RADIX_LOG2 must be 1 or 2");
      end
   endgenerate

   logic                   core_busy;
   logic                   core_fin;
   logic                   accept;
   logic [PW-1:0]          prod;
   logic signed [XLEN-1:0] mcand;
   logic signed [XLEN-1:0] mplr;
   logic [CW-1:0]          nsteps;
   logic [1:0]             size_q;
   logic [1:0]             form_q;
   logic [XLEN-1:0]        fmt_lo;
   logic [XLEN-1:0]        fmt_hi;
   logic                   fmt_sf;
   logic                   fmt_ovf;

   assign accept = start_i & ~core_busy;
   assign nsteps = CW'(size_bits(opsz_e'(size_i)) / RADIX_LOG2);

   smul_opnd_prep #(.XLEN(XLEN), .IMM_W(IMM_W)) u_prep (
      .size_i     (size_i),
      .form_i     (form_i),
      .src_a_i    (src_a_i),
      .src_b_i    (src_b_i),
      .imm_i      (imm_i),
      .imm_wide_i (imm_wide_i),
      .mcand_o    (mcand),
      .mplr_o     (mplr)
   );

   smul_booth_core #(.XLEN(XLEN), .RADIX_LOG2(RADIX_LOG2)) u_core (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .go_i     (accept),
      .nsteps_i (nsteps),
      .mcand_i  (mcand),
      .mplr_i   (mplr),
      .busy_o   (core_busy),
      .fin_o    (core_fin),
      .prod_o   (prod)
   );

   smul_result_fmt #(.XLEN(XLEN)) u_fmt (
      .prod_i (prod),
      .size_i (size_q),
      .form_i (form_q),
      .lo_o   (fmt_lo),
      .hi_o   (fmt_hi),
      .sf_o   (fmt_sf),
      .ovf_o  (fmt_ovf)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         size_q   <= '0;
         form_q   <= '0;
         done_o   <= 1'b0;
         res_lo_o <= '0;
         res_hi_o <= '0;
         sf_o     <= 1'b0;
         cf_o     <= 1'b0;
         of_o     <= 1'b0;
      end else begin
         if (accept) begin
            size_q <= size_i;
            form_q <= form_i;
         end
         done_o <= core_fin;
         if (core_fin) begin
            res_lo_o <= fmt_lo;
            res_hi_o <= fmt_hi;
            sf_o     <= fmt_sf;
            cf_o     <= fmt_ovf;
            of_o     <= fmt_ovf;
         end
      end
   end

   assign zf_o = 1'b0;
   assign af_o = 1'b0;
   assign pf_o = 1'b0;

endmodule

// File: rtl/smul_unit_chk.sv
module smul_unit_chk #(
   parameter int unsigned XLEN = 64
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            start_i,
   input logic            busy_i,
   input logic [1:0]      size_q_i,
   input logic [1:0]      form_q_i,
   input logic            done_i,
   input logic [XLEN-1:0] res_lo_i,
   input logic [XLEN-1:0] res_hi_i,
   input logic            sf_i,
   input logic            of_i,
   input logic            cf_i
);

   int unsigned     w_c;
   int unsigned     wl_c;
   logic [XLEN-1:0] mask_c;
   logic [XLEN-1:0] mask_l;
   logic            msb_c;
   logic            acc_ovf_c;

   always_comb begin
      w_c    = 32'd8 << size_q_i;
      wl_c   = (form_q_i == 2'b00 && size_q_i == 2'b00) ? 16 : w_c;
      mask_c = ~({XLEN{1'b1}} << w_c);
      mask_l = ~({XLEN{1'b1}} << wl_c);
      msb_c  = |(res_lo_i & (XLEN'(1) << (w_c - 1)));
      if (size_q_i == 2'b00)
         acc_ovf_c = (res_lo_i[15:8] != {8{msb_c}});
      else
         acc_ovf_c = (res_hi_i != (msb_c ? mask_c : '0));
   end

   // R1
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |=> !done_i);

   // R1
   result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_i |-> ($stable(res_lo_i) && $stable(res_hi_i) && $stable({sf_i, cf_i, of_i})));

   // R2
   busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i && start_i) |=> ($stable(size_q_i) && $stable(form_q_i)));

   // R5
   narrow_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i && form_q_i != 2'b00) |-> (res_hi_i == '0));

   // R7
   upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |-> ((res_lo_i & ~mask_l) == '0 && (res_hi_i & ~mask_c) == '0));

   // R8
   acc_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i && form_q_i == 2'b00) |-> (of_i == acc_ovf_c && cf_i == acc_ovf_c));

   // R9
   sign_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |-> (sf_i == msb_c));

endmodule

bind smul_unit smul_unit_chk #(.XLEN(XLEN)) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .start_i  (start_i),
   .busy_i   (core_busy),
   .size_q_i (size_q),
   .form_q_i (form_q),
   .done_i   (done_o),
   .res_lo_i (res_lo_o),
   .res_hi_i (res_hi_o),
   .sf_i     (sf_o),
   .of_i     (of_o),
   .cf_i     (cf_o)
);

// File: tb/smul_unit_tb.sv
`timescale 1ns/1ps
module smul_unit_tb;

   localparam int unsigned XLEN       = 64;
   localparam int unsigned IMM_W      = 32;
   localparam int unsigned RADIX_LOG2 = 2;
   localparam int          WDOG_LIM   = 150000;

   typedef struct packed {
      logic [1:0]  sz;
      logic [1:0]  fm;
      logic [63:0] a;
      logic [63:0] b;
      logic [31:0] imm;
      logic        iw;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 2'd0, 64'h80, 64'hFF, 32'h0, 1'b0},                           // R3 R4 -128*-1 acc
      '{2'd0, 2'd1, 64'h80, 64'hFF, 32'h0, 1'b0},                           // R5 R8 truncated
      '{2'd1, 2'd0, 64'h8000, 64'h8000, 32'h0, 1'b0},
      '{2'd2, 2'd0, 64'h80000000, 64'hFFFFFFFF, 32'h0, 1'b0},
      '{2'd3, 2'd0, 64'h8000000000000000, 64'hFFFFFFFFFFFFFFFF, 32'h0, 1'b0},
      '{2'd3, 2'd0, 64'h8000000000000000, 64'h8000000000000000, 32'h0, 1'b0},
      '{2'd2, 2'd1, 64'hDEADBEEF00000007, 64'h12345678FFFFFFFD, 32'h0, 1'b0},// R7 upper bits dropped
      '{2'd1, 2'd1, 64'h0, 64'h8000, 32'h0, 1'b0},
      '{2'd2, 2'd2, 64'd1000, 64'h5555AAAA5555AAAA, 32'h000000F0, 1'b0},     // R6 imm8
      '{2'd2, 2'd2, 64'd1000, 64'h0123456789ABCDEF, 32'h000000F0, 1'b0},     // R6 other b
      '{2'd1, 2'd2, 64'h7FFF, 64'h0, 32'h00008001, 1'b1},                    // R6 imm16
      '{2'd3, 2'd2, 64'h100000000, 64'h0, 32'h80000000, 1'b1},               // R6 imm32 fits
      '{2'd0, 2'd2, 64'h7F, 64'h0, 32'h7FFFFF81, 1'b1},                      // R6 size 8 wide
      '{2'd2, 2'd3, 64'h7FFFFFFF, 64'h2, 32'h0, 1'b0},                       // R5 spare form
      '{2'd1, 2'd0, 64'h7FFF, 64'h7FFF, 32'h0, 1'b0},
      '{2'd0, 2'd0, 64'h0, 64'h5A, 32'h0, 1'b0},
      '{2'd3, 2'd1, 64'h7FFFFFFFFFFFFFFF, 64'h2, 32'h0, 1'b0}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [1:0]       size = '0;
   logic [1:0]       form = '0;
   logic [XLEN-1:0]  a = '0;
   logic [XLEN-1:0]  b = '0;
   logic [IMM_W-1:0] imm = '0;
   logic             immw = 1'b0;
   logic             done;
   logic [XLEN-1:0]  res_lo;
   logic [XLEN-1:0]  res_hi;
   logic             sf, cf, of_f, zf, af, pf;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2 clk = ~clk;

   smul_unit #(.XLEN(XLEN), .IMM_W(IMM_W), .RADIX_LOG2(RADIX_LOG2)) u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .start_i    (start),
      .size_i     (size),
      .form_i     (form),
      .src_a_i    (a),
      .src_b_i    (b),
      .imm_i      (imm),
      .imm_wide_i (immw),
      .done_o     (done),
      .res_lo_o   (res_lo),
      .res_hi_o   (res_hi),
      .sf_o       (sf),
      .cf_o       (cf),
      .of_o       (of_f),
      .zf_o       (zf),
      .af_o       (af),
      .pf_o       (pf)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WDOG_LIM) begin
         fails = fails + 1;
         $display("FAIL R1 watchdog: actual %0d cycles, expected fewer than %0d", cyc, WDOG_LIM);
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic signed [127:0] sx(input logic [1:0] sz, input logic [63:0] v);
      case (sz)
         2'd0:    return $signed(v[7:0]);
         2'd1:    return $signed(v[15:0]);
         2'd2:    return $signed(v[31:0]);
         default: return $signed(v);
      endcase
   endfunction

   task automatic model(input logic [1:0] sz, input logic [1:0] fm,
                        input logic [63:0] av, input logic [63:0] bv,
                        input logic [31:0] iv, input logic iw,
                        output logic [63:0] elo, output logic [63:0] ehi,
                        output logic esf, output logic eov);
      logic signed [127:0] x, y, p, tr, im;
      x = sx(sz, av);
      if (fm == 2'd2) begin
         if (!iw || sz == 2'd0) im = $signed(iv[7:0]);
         else if (sz == 2'd1)   im = $signed(iv[15:0]);
         else                   im = $signed(iv);
         y = sx(sz, im[63:0]);
      end else begin
         y = sx(sz, bv);
      end
      p = x * y;
      case (sz)
         2'd0:    begin tr = $signed(p[7:0]);  esf = p[7];  end
         2'd1:    begin tr = $signed(p[15:0]); esf = p[15]; end
         2'd2:    begin tr = $signed(p[31:0]); esf = p[31]; end
         default: begin tr = $signed(p[63:0]); esf = p[63]; end
      endcase
      eov = (tr != p);
      ehi = '0;
      if (fm == 2'd0) begin
         case (sz)
            2'd0:    elo = {48'b0, p[15:0]};
            2'd1:    begin elo = {48'b0, p[15:0]}; ehi = {48'b0, p[31:16]}; end
            2'd2:    begin elo = {32'b0, p[31:0]}; ehi = {32'b0, p[63:32]}; end
            default: begin elo = p[63:0];          ehi = p[127:64];        end
         endcase
      end else begin
         case (sz)
            2'd0:    elo = {56'b0, p[7:0]};
            2'd1:    elo = {48'b0, p[15:0]};
            2'd2:    elo = {32'b0, p[31:0]};
            default: elo = p[63:0];
         endcase
      end
   endtask

   // wait for done, return edges after the accepting edge
   task automatic wait_done(output int lat);
      lat = 0;
      while (!done && lat < 80) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic run_op(input logic [1:0] sz, input logic [1:0] fm,
                         input logic [63:0] av, input logic [63:0] bv,
                         input logic [31:0] iv, input logic iw);
      logic [63:0] elo, ehi;
      logic        esf, eov;
      int          lat;
      int          steps;
      model(sz, fm, av, bv, iv, iw, elo, ehi, esf, eov);
      steps = (8 << sz) / RADIX_LOG2;
      @(negedge clk);
      size = sz; form = fm; a = av; b = bv; imm = iv; immw = iw; start = 1'b1;
      @(negedge clk);
      start = 1'b0; size = ~sz; form = ~fm; a = ~av; b = ~bv; imm = ~iv; immw = ~iw;
      wait_done(lat);
      check("R11", "latency", 64'(lat), 64'(steps + 1));
      check(fm == 2'd0 ? "R4" : "R5", "res_lo", res_lo, elo);
      check(fm == 2'd0 ? "R4 R7" : "R5 R7", "res_hi", res_hi, ehi);
      check("R9", "sf", 64'(sf), 64'(esf));
      check("R8", "cf", 64'(cf), 64'(eov));
      check("R8", "of", 64'(of_f), 64'(eov));
      @(negedge clk);
      check("R1", "done width", 64'(done), 64'd0);
      check("R1", "res_lo hold", res_lo, elo);
   endtask

   initial begin
      logic [63:0] elo, ehi;
      logic        esf, eov;
      int          lat;
      int          seen;

      // R10 outputs during reset
      repeat (3) @(negedge clk);
      check("R10", "done in reset", 64'(done), 64'd0);
      check("R10", "res_lo in reset", res_lo, 64'd0);
      check("R10", "res_hi in reset", res_hi, 64'd0);
      check("R10", "flags in reset", 64'({sf, cf, of_f}), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3 R4 R5 R6 R7 R8 R9 table
      for (int i = 0; i < NV; i++)
         run_op(VECS[i].sz, VECS[i].fm, VECS[i].a, VECS[i].b, VECS[i].imm, VECS[i].iw);

      // R2 start while busy is dropped
      model(2'd2, 2'd1, 64'd1234567, -64'sd89, 32'h0, 1'b0, elo, ehi, esf, eov);
      @(negedge clk);
      size = 2'd2; form = 2'd1; a = 64'd1234567; b = -64'sd89; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      size = 2'd0; form = 2'd0; a = 64'h7F; b = 64'h7F; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(lat);
      check("R2", "latency with dropped start", 64'(lat + 4), 64'(32 / RADIX_LOG2 + 1));
      check("R2", "res_lo with dropped start", res_lo, elo);
      seen = 0;
      @(negedge clk);
      for (int k = 0; k < 40; k++) begin
         if (done) seen++;
         @(negedge clk);
      end
      check("R2", "extra done count", 64'(seen), 64'd0);

      // R10 reset in the middle of an operation
      @(negedge clk);
      size = 2'd3; form = 2'd0; a = 64'd77; b = 64'd99; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R10", "res_lo after mid-run reset", res_lo, 64'd0);
      check("R10", "done after mid-run reset", 64'(done), 64'd0);
      rst_n = 1'b1;
      seen = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (done) seen++;
      end
      check("R10", "done after abandoned run", 64'(seen), 64'd0);

      // R3 random operands, all sizes and forms
      for (int n = 0; n < 240; n++) begin
         logic [63:0] ra, rb;
         logic [1:0]  rs, rf;
         ra = {$urandom, $urandom};
         rb = {$urandom, $urandom};
         rs = 2'($urandom % 4);
         rf = 2'($urandom % 4);
         case ($urandom % 8)
            0: ra = 64'h8000000000000000 >>> (64 - (8 << rs));
            1: rb = '1;
            2: ra = '0;
            default: ;
         endcase
         run_op(rs, rf, ra, rb, $urandom, 1'($urandom % 2));
      end

      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule